// File: doc/BRIEF.md
# Master Per-Slot Delay Aggregator

In a time-slotted star network the master must tell every slave how late that slave's burst was heard, with the master's own send latency added. This block works on the master side. Each slave slot is announced with its index and the timer tick on which that slave was scheduled to launch. The block watches the receive first-bit flag. On the first rising edge inside the slot it records the arrival delay, which is the current timer value minus the scheduled tick, and files it under that slot.

When the master opens its own frame it supplies its scheduled send tick. The first rising edge of the transmit first-bit flag gives the master's transmit delay. That flag rises while the frame is still being assembled. The block then streams one correction term per slot, in ascending slot order, on a valid/ready interface. Each term is the stored receive delay plus the master's transmit delay, clamped to a signed width. A flag beside each term says whether the slot actually produced an arrival edge. The framing logic places these terms at the head of the outgoing frame.

Top module: `theta_agg`

## Requirements
- R1: After reset `out_valid_o` is 0 and every slot entry is invalid (`out_ok_o` = 0 when streamed) with a stored delay of 0.
- R2: After `slot_open_i`, the first rising edge of `rx_first_i` stores the timer value at that edge minus `sched_tick_i`, taken modulo 2^TIMER_W as a signed number, under the open slot and marks the entry valid. Further edges in the same slot are ignored.
- R3: Opening a slot marks its entry invalid at once. If no receive edge follows before the slot closes, the entry is streamed with `out_ok_o` = 0, and its term is formed from the last stored delay.
- R4: After `frame_open_i`, the first rising edge of `tx_first_i` sets the transmit delay to the timer value minus the `sched_tick_i` latched at `frame_open_i` (modulo 2^TIMER_W, signed). That edge starts a stream.
- R5: Each streamed term is the receive delay plus the transmit delay. It is clamped to the range -2^(THETA_W-1) to 2^(THETA_W-1)-1 and does not wrap.
- R6: A stream presents exactly NODES entries, with indices 0, 1, … NODES-1 in that order. The index advances on each cycle where valid and ready are both high. `out_valid_o` falls after the last entry is accepted.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the index, term and flag all hold steady.
- R8: A transmit edge with no pending `frame_open_i`, or one that arrives while a stream is running, starts no stream.
- R9: A receive edge with no slot open (after `frame_open_i` has closed it) is ignored. A slot index of NODES or more changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_i | input | TIMER_W | Free-running local time |
| sched_tick_i | input | TIMER_W | Scheduled tick, sampled with `slot_open_i` or `frame_open_i` |
| slot_open_i | input | 1 | One-cycle pulse that opens slave slot `slot_idx_i` |
| slot_idx_i | input | $clog2(NODES) | Index of the slot being opened |
| frame_open_i | input | 1 | One-cycle pulse that opens the master frame and closes the slot |
| rx_first_i | input | 1 | Level flag, high from the first received payload bit |
| tx_first_i | input | 1 | Level flag, high from the first transmitted payload bit |
| out_valid_o | output | 1 | Stream entry valid |
| out_ready_i | input | 1 | Stream entry accepted |
| out_idx_o | output | $clog2(NODES) | Slot index of the entry |
| out_theta_o | output | THETA_W | Clamped signed correction term |
| out_ok_o | output | 1 | Slot produced an arrival edge |

## Verification
The bench builds the block with NODES=6, TIMER_W=10 and THETA_W=8. Six slots make the index width three bits, so the unused codes 6 and 7 can be driven to show they touch nothing. The 8-bit term width lets delays of a hundred ticks or so drive the sum past both clamp limits. The 10-bit timer makes every early arrival a subtraction that wraps. Ready is driven both constantly high and from a pseudo-random pattern, so both stalls and back-to-back transfers occur.

// File: rtl/theta_agg_pkg.sv
package theta_agg_pkg;

    localparam int DEF_NODES   = 8;
    localparam int DEF_TIMER_W = 16;
    localparam int DEF_THETA_W = 12;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ARMED = 1'b1
    } frame_phase_e;

    typedef struct packed {
        logic open;
        logic seen;
    } slot_flags_t;

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/delay_table.sv
module delay_table
    import theta_agg_pkg::*;
#(
    parameter int NODES   = DEF_NODES,
    parameter int TIMER_W = DEF_TIMER_W,
    localparam int IW     = $clog2(NODES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [TIMER_W-1:0]         timer_i,
    input  logic [TIMER_W-1:0]         sched_i,
    input  logic                       slot_open_i,
    input  logic [IW-1:0]              slot_idx_i,
    input  logic                       frame_open_i,
    input  logic                       rx_rise_i,
    input  logic [IW-1:0]              rd_idx_i,
    output logic signed [TIMER_W-1:0]  rd_delay_o,
    output logic                       rd_ok_o
);
    slot_flags_t              flags_q;
    logic [IW-1:0]            cur_idx_q;
    logic [TIMER_W-1:0]       cur_sched_q;
    logic signed [TIMER_W-1:0] delay_q [NODES];
    logic [NODES-1:0]         ok_q;
    logic                     capture;
    logic signed [TIMER_W-1:0] delta;

    assign capture = rx_rise_i & flags_q.open & ~flags_q.seen & ~slot_open_i;
    assign delta   = signed'(timer_i - cur_sched_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q     <= '0;
            cur_idx_q   <= '0;
            cur_sched_q <= '0;
        end else if (slot_open_i) begin
            flags_q     <= '{open: 1'b1, seen: 1'b0};
            cur_idx_q   <= slot_idx_i;
            cur_sched_q <= sched_i;
        end else if (frame_open_i) begin
            flags_q.open <= 1'b0;
        end else if (capture) begin
            flags_q.seen <= 1'b1;
        end
    end

    for (genvar k = 0; k < NODES; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                delay_q[k] <= '0;
                ok_q[k]    <= 1'b0;
            end else if (slot_open_i && slot_idx_i == IW'(k)) begin
                ok_q[k]    <= 1'b0;
            end else if (capture && cur_idx_q == IW'(k)) begin
                delay_q[k] <= delta;
                ok_q[k]    <= 1'b1;
            end
        end
    end

    assign rd_delay_o = delay_q[rd_idx_i];
    assign rd_ok_o    = ok_q[rd_idx_i];

    // R3: a freshly opened slot reads as invalid on the following cycle
    assert_open_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (slot_open_i && ({1'b0, slot_idx_i} < NODES[IW:0])) |=> !ok_q[$past(slot_idx_i)]);

    // R2: an accepted first edge leaves the owning entry valid
    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (capture && ({1'b0, cur_idx_q} < NODES[IW:0])) |=> ok_q[$past(cur_idx_q)]);
endmodule

// File: rtl/theta_stream.sv
module theta_stream
    import theta_agg_pkg::*;
#(
    parameter int NODES   = DEF_NODES,
    parameter int TIMER_W = DEF_TIMER_W,
    parameter int THETA_W = DEF_THETA_W,
    localparam int IW     = $clog2(NODES),
    localparam int SW     = TIMER_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic signed [TIMER_W-1:0]  tx_delay_i,
    output logic [IW-1:0]              rd_idx_o,
    input  logic signed [TIMER_W-1:0]  rd_delay_i,
    input  logic                       rd_ok_i,
    output logic                       out_valid_o,
    input  logic                       out_ready_i,
    output logic [IW-1:0]              out_idx_o,
    output logic signed [THETA_W-1:0]  out_theta_o,
    output logic                       out_ok_o
);
    localparam int HI = (1 <<< (THETA_W - 1)) - 1;
    localparam int LO = -(1 <<< (THETA_W - 1));
    localparam logic signed [SW-1:0] HI_S = SW'(HI);
    localparam logic signed [SW-1:0] LO_S = SW'(LO);

    logic                      sending_q;
    logic [IW-1:0]             idx_q;
    logic signed [TIMER_W-1:0] txd_q;
    logic signed [SW-1:0]      sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            sending_q <= 1'b0;
            idx_q     <= '0;
            txd_q     <= '0;
        end else if (!sending_q && start_i) begin
            sending_q <= 1'b1;
            idx_q     <= '0;
            txd_q     <= tx_delay_i;
        end else if (sending_q && out_ready_i) begin
            if (idx_q == IW'(NODES - 1)) sending_q <= 1'b0;
            else                         idx_q     <= idx_q + 1'b1;
        end
    end

    always_comb begin
        sum = signed'({rd_delay_i[TIMER_W-1], rd_delay_i}) +
              signed'({txd_q[TIMER_W-1], txd_q});
        if (sum > HI_S)      out_theta_o = THETA_W'(HI);
        else if (sum < LO_S) out_theta_o = THETA_W'(LO);
        else                 out_theta_o = THETA_W'(sum);
    end

    assign rd_idx_o    = idx_q;
    assign out_idx_o   = idx_q;
    assign out_valid_o = sending_q;
    assign out_ok_o    = rd_ok_i;

    // R7: stalled entry holds
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_idx_o) && $stable(out_theta_o) && $stable(out_ok_o)));

    // R6: every stream begins at slot 0
    assert_first_idx_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid_o) |-> (out_idx_o == '0));

    // R6: accepting the last slot ends the stream
    assert_last_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_ready_i && out_idx_o == IW'(NODES - 1)) |=> !out_valid_o);

    // R8: no stream appears without a start request
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (!out_valid_o && !start_i) |=> !out_valid_o);
endmodule

// File: rtl/theta_agg.sv
module theta_agg
    import theta_agg_pkg::*;
#(
    parameter int NODES   = DEF_NODES,
    parameter int TIMER_W = DEF_TIMER_W,
    parameter int THETA_W = DEF_THETA_W,
    localparam int IW     = $clog2(NODES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [TIMER_W-1:0]        timer_i,
    input  logic [TIMER_W-1:0]        sched_tick_i,
    input  logic                      slot_open_i,
    input  logic [IW-1:0]             slot_idx_i,
    input  logic                      frame_open_i,
    input  logic                      rx_first_i,
    input  logic                      tx_first_i,
    output logic                      out_valid_o,
    input  logic                      out_ready_i,
    output logic [IW-1:0]             out_idx_o,
    output logic signed [THETA_W-1:0] out_theta_o,
    output logic                      out_ok_o
);
    logic                      rx_rise, tx_rise, start;
    frame_phase_e              phase_q;
    logic [TIMER_W-1:0]        tm_q;
    logic signed [TIMER_W-1:0] tx_delta;
    logic [IW-1:0]             rd_idx;
    logic signed [TIMER_W-1:0] rd_delay;
    logic                      rd_ok;

    rise_detect u_rx_edge (.clk(clk), .rst(rst), .level_i(rx_first_i), .rise_o(rx_rise));
    rise_detect u_tx_edge (.clk(clk), .rst(rst), .level_i(tx_first_i), .rise_o(tx_rise));

    assign start    = tx_rise && (phase_q == PH_ARMED) && !out_valid_o;
    assign tx_delta = signed'(timer_i - tm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            tm_q    <= '0;
        end else if (frame_open_i) begin
            phase_q <= PH_ARMED;
            tm_q    <= sched_tick_i;
        end else if (start) begin
            phase_q <= PH_IDLE;
        end
    end

    delay_table #(.NODES(NODES), .TIMER_W(TIMER_W)) u_table (
        .clk(clk), .rst(rst), .timer_i(timer_i), .sched_i(sched_tick_i),
        .slot_open_i(slot_open_i), .slot_idx_i(slot_idx_i),
        .frame_open_i(frame_open_i), .rx_rise_i(rx_rise),
        .rd_idx_i(rd_idx), .rd_delay_o(rd_delay), .rd_ok_o(rd_ok)
    );

    theta_stream #(.NODES(NODES), .TIMER_W(TIMER_W), .THETA_W(THETA_W)) u_stream (
        .clk(clk), .rst(rst), .start_i(start), .tx_delay_i(tx_delta),
        .rd_idx_o(rd_idx), .rd_delay_i(rd_delay), .rd_ok_i(rd_ok),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_idx_o(out_idx_o), .out_theta_o(out_theta_o), .out_ok_o(out_ok_o)
    );

    // R4: a transmit edge in the armed phase leaves the block streaming
    assert_tx_starts_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_rise && phase_q == PH_ARMED && !frame_open_i) |=> out_valid_o);
endmodule

// File: tb/theta_agg_tb_top.sv
module theta_agg_tb_top;
    localparam int NODES = 6;
    localparam int TW    = 10;
    localparam int THW   = 8;
    localparam int IW    = $clog2(NODES);
    localparam int TMOD  = 1 << TW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [TW-1:0] sched = '0;
    logic slot_open = 1'b0, frame_open = 1'b0, rx = 1'b0, tx = 1'b0;
    logic [IW-1:0] slot_idx = '0;
    logic out_valid, out_ok, rdy;
    logic [IW-1:0] out_idx;
    logic signed [THW-1:0] out_theta;
    int tmr = 0;
    logic [7:0] lfsr = 8'h5A;
    bit rdy_rand = 1'b0;

    int n_chk = 0, n_fail = 0, beats = 0, cyc = 0;
    bit done = 1'b0;
    int got_theta [NODES];
    bit got_ok [NODES];

    always #2.5 clk = ~clk;

    theta_agg #(.NODES(NODES), .TIMER_W(TW), .THETA_W(THW)) dut_i (
        .clk(clk), .rst(rst), .timer_i(tmr[TW-1:0]), .sched_tick_i(sched),
        .slot_open_i(slot_open), .slot_idx_i(slot_idx), .frame_open_i(frame_open),
        .rx_first_i(rx), .tx_first_i(tx), .out_valid_o(out_valid),
        .out_ready_i(rdy), .out_idx_o(out_idx), .out_theta_o(out_theta), .out_ok_o(out_ok)
    );

    always @(posedge clk) begin
        tmr  <= rst ? 0 : (tmr + 1) % TMOD;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    assign rdy = rdy_rand ? lfsr[0] : 1'b1;

    function automatic int wrapd(int t, int s);
        int d = ((t - s) % TMOD + TMOD) % TMOD;
        return (d >= TMOD / 2) ? d - TMOD : d;
    endfunction

    function automatic int satv(int v);
        if (v > (1 << (THW - 1)) - 1) return (1 << (THW - 1)) - 1;
        if (v < -(1 << (THW - 1)))    return -(1 << (THW - 1));
        return v;
    endfunction

    function automatic logic [TW-1:0] tick(int v);
        return TW'(((v % TMOD) + TMOD) % TMOD);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    int  m_tab [NODES];
    bit  m_ok [NODES];
    bit  m_open, m_seen, m_armed, m_send, rxp, txp;
    int  m_cur, m_sched, m_tm, m_idx, m_txd;

    always @(posedge clk) begin : model
        bit rr, tr, cap, st;
        if (rst) begin
            foreach (m_tab[k]) begin m_tab[k] = 0; m_ok[k] = 0; end
            m_open = 0; m_seen = 0; m_armed = 0; m_send = 0;
            m_cur = 0; m_sched = 0; m_tm = 0; m_idx = 0; m_txd = 0;
            rxp = 0; txp = 0;
        end else begin
            rr  = rx && !rxp;
            tr  = tx && !txp;
            cap = rr && m_open && !m_seen && !slot_open;
            st  = tr && m_armed && !m_send;
            if (m_send && rdy) begin
                if (m_idx == NODES - 1) m_send = 0; else m_idx++;
            end else if (st) begin
                m_send = 1; m_idx = 0; m_txd = wrapd(tmr, m_tm);
            end
            if (frame_open) begin m_armed = 1; m_tm = sched; end
            else if (st) m_armed = 0;
            if (cap) begin
                if (m_cur < NODES) begin m_tab[m_cur] = wrapd(tmr, m_sched); m_ok[m_cur] = 1; end
                m_seen = 1;
            end
            if (slot_open) begin
                m_open = 1; m_seen = 0; m_cur = slot_idx; m_sched = sched;
                if (slot_idx < NODES) m_ok[slot_idx] = 0;
            end else if (frame_open) m_open = 0;
            rxp = rx; txp = tx;
        end
    end

    // per-cycle comparison and stream capture, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(out_valid == m_send, "R6 valid", out_valid, m_send);
            if (m_send && out_valid) begin
                chk(out_idx == m_idx, "R6 index", out_idx, m_idx);
                chk(out_theta == satv(m_tab[m_idx] + m_txd), "R5 term",
                    out_theta, satv(m_tab[m_idx] + m_txd));
                chk(out_ok == m_ok[m_idx], "R3 flag", out_ok, m_ok[m_idx]);
            end
            if (out_valid && rdy) begin
                got_theta[out_idx] = out_theta;
                got_ok[out_idx]    = out_ok;
                beats++;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic rx_pulse();
        @(negedge clk) rx = 1'b1;
        @(negedge clk) rx = 1'b0;
    endtask

    task automatic open_only(int idx);
        @(negedge clk);
        slot_open = 1'b1; slot_idx = IW'(idx); sched = tick(tmr);
        @(negedge clk) slot_open = 1'b0;
    endtask

    // edge at the cycle after the open, with delay d relative to sched
    task automatic receive(int idx, int d);
        @(negedge clk);
        slot_open = 1'b1; slot_idx = IW'(idx); sched = tick(tmr + 1 - d);
        @(negedge clk); slot_open = 1'b0; rx = 1'b1;
        @(negedge clk) rx = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(int dtx, bit stray);
        int k = stray ? 2 : 1;
        beats = 0;
        @(negedge clk);
        frame_open = 1'b1; sched = tick(tmr + k - dtx);
        @(negedge clk); frame_open = 1'b0;
        if (stray) begin rx = 1'b1; @(negedge clk); rx = 1'b0; end
        tx = 1'b1;
        @(negedge clk) tx = 1'b0;
    endtask

    task automatic check_stream(string tag, int exp_t [NODES], bit exp_o [NODES]);
        repeat (60) @(negedge clk);
        chk(beats == NODES, {tag, " R6 beat count"}, beats, NODES);
        for (int k = 0; k < NODES; k++) begin
            chk(got_theta[k] == exp_t[k], {tag, " R5 term"}, got_theta[k], exp_t[k]);
            chk(got_ok[k] == exp_o[k], {tag, " R3 flag"}, got_ok[k], exp_o[k]);
        end
    endtask

    initial begin
        int t0 [NODES];
        bit o0 [NODES];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);

        // R8: transmit edge with no frame pending
        beats = 0;
        @(negedge clk) tx = 1'b1;
        @(negedge clk) tx = 1'b0;
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0 && beats == 0, "R8 no frame no stream", beats, 0);

        // R1/R4: all entries invalid, term equals transmit delay alone
        frame(5, 1'b0);
        t0 = '{5, 5, 5, 5, 5, 5};
        o0 = '{0, 0, 0, 0, 0, 0};
        check_stream("R1 R4 reset table", t0, o0);

        // round 1: R2 delays, clamps, R3 empty slot, R9 stray edge, random ready
        rdy_rand = 1'b1;
        receive(0, 3);
        receive(1, 7);
        rx_pulse();                 // R2: second edge in slot 1 ignored
        receive(2, -4);
        receive(3, 120);
        receive(4, -100);
        open_only(5);
        frame(20, 1'b1);            // R9: edge after frame open is ignored
        t0 = '{23, 27, 16, 127, -80, 20};
        o0 = '{1, 1, 1, 1, 1, 0};
        check_stream("round1", t0, o0);

        // round 2: negative clamp, reopened empty slot, out-of-range index
        rdy_rand = 1'b0;
        receive(0, -30);
        open_only(1);
        receive(7, 50);             // R9: index beyond NODES touches nothing
        frame(-110, 1'b0);
        @(negedge clk);
        frame_open = 1'b1; sched = tick(tmr);
        @(negedge clk) frame_open = 1'b0; tx = 1'b1;   // R8: edge during stream
        @(negedge clk) tx = 1'b0;
        t0 = '{-128, -103, -114, 10, -128, -110};
        o0 = '{1, 0, 1, 1, 1, 0};
        check_stream("round2 R8", t0, o0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule